// File: doc/BRIEF.md
# Tiled single-port SRAM wrapper

This block presents one logical single-port synchronous memory that is built from a two-dimensional grid of identical, smaller memory tiles. The logical word is cut into column slices that sit side by side. The logical depth is cut into row banks, and the upper address bits choose the bank. Every tile sees the low address bits, its slice of the write data and a write mask derived for its own granularity. Chip enable, write enable and read enable reach each tile only when its bank is addressed. Read data comes back one clock after an enabled read. It is assembled from the column tiles of the bank that was read, which is selected by a bank index captured at the time of that read.

Two build-time variants cover tiles whose interface differs from the logical port. A tile without a mask input has the granule's mask bit folded into its write enable, and the slices are then narrowed so that each one lies inside a single granule. A logical port without a read enable drives the tile read enables from the inverted write enable instead. The access interface is a plain memory port with no back-pressure: one access is accepted on every clock edge where chip enable is high, and no handshake is needed.

Top module: `tiled_sram`

## Requirements
- R1: A full-mask write followed by a read of the same address returns the whole written word, bit for bit. This holds for every address below DEPTH.
- R2: Address a (below DEPTH) lives in bank a / TILE_D at tile row a % TILE_D. Writes on one side of a bank boundary (for example 15/16, 31/32) never disturb the word on the other side.
- R3: Only the addressed bank is written. A write to an address at or above DEPTH changes no stored word, even though its low bits alias a real row.
- R4: The data of a read is on mem_rdata at the first clock edge after the edge that samples mem_ce=1, mem_re=1, mem_we=0. It stays there until the next read.
- R5: With PORT_HAS_RE=1, mem_rdata holds its value on every edge without mem_ce=1 and mem_re=1 together. This includes edges that write the address last read.
- R6: A read of an address at or above DEPTH returns all zeros.
- R7: Write mask bit i enables data bits [i*MASK_GRAN +: MASK_GRAN]. Bits whose mask bit is 0 keep their old value. This holds with tiles that have a finer mask of their own (TILE_GRAN < TILE_W).
- R8: With PORT_HAS_RE=0, mem_re has no effect. Every edge with mem_ce=1 and mem_we=0 is a read.
- R9: With tiles that have no mask input (TILE_GRAN = TILE_W), masked writes give the same stored words as in R7.
- R10: After reset, mem_rdata is zero until the first read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read path registers |
| mem_ce | input | 1 | Chip enable; an access happens only when high |
| mem_we | input | 1 | Write enable (1 write, 0 read) |
| mem_re | input | 1 | Read enable (ignored when PORT_HAS_RE=0) |
| mem_addr | input | $clog2(DEPTH) | Word address |
| mem_wdata | input | DATA_W | Write data |
| mem_wmask | input | DATA_W/MASK_GRAN | Write mask, one bit per MASK_GRAN-bit granule, LSB first |
| mem_rdata | output | DATA_W | Read data, one cycle after the read |

## Verification
Writes take effect at the edge that samples them. Reads deliver their data at that same edge, so it is visible on mem_rdata from the following clock low phase until the next read. The bench drives each access at a falling edge and samples mem_rdata at the next falling edge, which is exactly one rising edge later. Hold checks are sampled one falling edge after a write or a disabled cycle, and compare mem_rdata against the value captured after the preceding read. The variant without a read enable is sampled only right after its read cycles, because its output is allowed to move on any enabled cycle.

// File: rtl/tiled_sram_pkg.sv
package tiled_sram_pkg;

  // Width of one column slice. A masked tile (tile_gran < tile_w) takes a
  // full tile unless the logical granule is finer than the tile granule.
  // An unmasked tile must keep every slice inside one logical granule.
  function automatic int slice_width(int tile_w, int mask_gran, int tile_gran);
    if (tile_gran < tile_w) begin
      return (mask_gran < tile_gran) ? mask_gran : tile_w;
    end
    return ((mask_gran % tile_w) == 0) ? tile_w : mask_gran;
  endfunction

  function automatic int ceil_div(int a, int b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/tiled_sram_tile.sv
module tiled_sram_tile #(
  parameter int W    = 8,
  parameter int D    = 16,
  parameter int GRAN = 2,
  localparam int AW  = $clog2(D),
  localparam int MW  = W / GRAN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [MW-1:0] wmask,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] store [D];

  always_ff @(posedge clk) begin
    if (ce && we) begin
      for (int k = 0; k < MW; k++) begin
        if (wmask[k]) store[addr][k*GRAN +: GRAN] <= wdata[k*GRAN +: GRAN];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rdata <= '0;
    else if (ce && re && !we)   rdata <= store[addr];
  end

endmodule

// File: rtl/tiled_sram_bank_sel.sv
module tiled_sram_bank_sel #(
  parameter int NB  = 3,
  parameter int BWS = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [BWS-1:0] idx,
  output logic [NB-1:0]  hit,
  output logic [BWS-1:0] sel_q
);

  for (genvar b = 0; b < NB; b++) begin : g_hit
    assign hit[b] = (idx == BWS'(b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_q <= '0;
    else if (load) sel_q <= idx;
  end

  // R5: the captured bank index only moves on an enabled read
  assert_sel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(sel_q));

  // R2: at most one bank decodes any address
  assert_one_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

endmodule

// File: rtl/tiled_sram_rdmux.sv
module tiled_sram_rdmux #(
  parameter int NB  = 3,
  parameter int DW  = 12,
  parameter int BWS = 2
) (
  input  logic [NB*DW-1:0] bank_rd,
  input  logic [BWS-1:0]   sel,
  output logic [DW-1:0]    rdata
);

  always_comb begin
    rdata = '0;
    for (int b = NB - 1; b >= 0; b--) begin
      if (sel == BWS'(b)) rdata = bank_rd[b*DW +: DW];
    end
  end

endmodule

// File: rtl/tiled_sram.sv
module tiled_sram #(
  parameter int DATA_W      = 12,
  parameter int DEPTH       = 48,
  parameter int TILE_W      = 8,
  parameter int TILE_D      = 16,
  parameter int MASK_GRAN   = 4,
  parameter int TILE_GRAN   = 2,
  parameter bit PORT_HAS_RE = 1'b1,
  localparam int AW = $clog2(DEPTH),
  localparam int MW = DATA_W / MASK_GRAN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_ce,
  input  logic              mem_we,
  input  logic              mem_re,
  input  logic [AW-1:0]     mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  input  logic [MW-1:0]     mem_wmask,
  output logic [DATA_W-1:0] mem_rdata
);

  localparam int  TAW   = $clog2(TILE_D);
  localparam int  NB    = DEPTH / TILE_D;
  localparam int  SW    = tiled_sram_pkg::slice_width(TILE_W, MASK_GRAN, TILE_GRAN);
  localparam int  NS    = tiled_sram_pkg::ceil_div(DATA_W, SW);
  localparam bit  TMASK = (TILE_GRAN < TILE_W);
  localparam int  TMW   = TILE_W / TILE_GRAN;
  localparam int  BWS   = (AW > TAW) ? AW - TAW : 1;

  logic [BWS-1:0]       bank_idx;
  logic [BWS-1:0]       sel_q;
  logic [NB-1:0]        hit;
  logic [NB-1:0]        bank_ce;
  logic [NB*NS-1:0]     tile_we_all;
  logic [NB*DATA_W-1:0] bank_rd;
  logic                 rd_load;
  logic [TAW-1:0]       row_addr;

  if (AW > TAW) begin : g_banked
    assign bank_idx = mem_addr[AW-1:TAW];
  end else begin : g_flat
    assign bank_idx = '0;
  end

  if (!PORT_HAS_RE) begin : g_no_re
    logic unused_re;
    assign unused_re = mem_re;
    assign rd_load   = mem_ce;
  end else begin : g_re
    assign rd_load   = mem_ce & mem_re;
  end

  assign row_addr = mem_addr[TAW-1:0];

  tiled_sram_bank_sel #(.NB(NB), .BWS(BWS)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (rd_load),
    .idx   (bank_idx),
    .hit   (hit),
    .sel_q (sel_q)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bank_ce[b] = mem_ce & hit[b];

    for (genvar j = 0; j < NS; j++) begin : g_col
      localparam int LSB = j * SW;
      localparam int WJ  = ((DATA_W - LSB) < SW) ? (DATA_W - LSB) : SW;

      logic [TILE_W-1:0] t_wd;
      logic [TILE_W-1:0] t_rd;
      logic [TMW-1:0]    t_wm;
      logic              t_we;
      logic              t_re;

      assign t_wd = TILE_W'(mem_wdata[LSB +: WJ]);

      if (TMASK) begin : g_tmask
        for (genvar k = 0; k < TMW; k++) begin : g_mbit
          localparam int POS = k * TILE_GRAN;
          if (POS >= WJ) begin : g_off
            assign t_wm[k] = 1'b0;
          end else begin : g_on
            assign t_wm[k] = mem_wmask[(LSB + POS) / MASK_GRAN];
          end
        end
        assign t_we = mem_we & hit[b];
      end else begin : g_tnomask
        assign t_wm = '1;
        assign t_we = mem_we & mem_wmask[LSB / MASK_GRAN] & hit[b];
      end

      if (PORT_HAS_RE) begin : g_pre
        assign t_re = mem_re & hit[b];
      end else begin : g_pnore
        assign t_re = ~mem_we & hit[b];
      end

      tiled_sram_tile #(.W(TILE_W), .D(TILE_D), .GRAN(TILE_GRAN)) u_tile (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (bank_ce[b]),
        .we    (t_we),
        .re    (t_re),
        .addr  (row_addr),
        .wdata (t_wd),
        .wmask (t_wm),
        .rdata (t_rd)
      );

      assign bank_rd[b*DATA_W + LSB +: WJ] = t_rd[WJ-1:0];
      assign tile_we_all[b*NS + j]         = t_we;

      if (WJ < TILE_W) begin : g_pad
        logic unused_pad;
        assign unused_pad = ^t_rd[TILE_W-1:WJ];
      end
    end
  end

  tiled_sram_rdmux #(.NB(NB), .DW(DATA_W), .BWS(BWS)) u_mux (
    .bank_rd (bank_rd),
    .sel     (sel_q),
    .rdata   (mem_rdata)
  );

  // R3: at most one row bank is enabled per access
  assert_single_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_ce));

  // R3: a write beyond the logical depth enables no tile write
  assert_no_oob_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ce && mem_we && (int'(mem_addr) >= DEPTH)) |-> (tile_we_all == '0));

  // R6: reading past the logical depth yields zero on the next cycle
  assert_oob_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ce && mem_re && !mem_we && (int'(mem_addr) >= DEPTH)) |=> (mem_rdata == '0));

  // R5: without an enabled read the output does not move
  assert_rdata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (PORT_HAS_RE && !(mem_ce && mem_re)) |=> $stable(mem_rdata));

endmodule

// File: tb/sim_tiled_sram.sv
`timescale 1ns/1ps
module sim_tiled_sram;

  localparam int DW = 12;
  localparam int DP = 48;
  localparam int AW = 6;
  localparam int MW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce = 1'b0, we = 1'b0, re = 1'b0;
  logic          re_tie = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wd = '0;
  logic [MW-1:0] wm = '0;
  logic [DW-1:0] rd0, rd1;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] mdl [64];

  always #5 clk = ~clk;

  // Masked tiles, port has read enable
  tiled_sram #(.DATA_W(DW), .DEPTH(DP), .TILE_W(8), .TILE_D(16), .MASK_GRAN(4),
               .TILE_GRAN(2), .PORT_HAS_RE(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_ce(ce), .mem_we(we), .mem_re(re),
    .mem_addr(addr), .mem_wdata(wd), .mem_wmask(wm), .mem_rdata(rd0));

  // Unmasked tiles, port without read enable (mem_re held at 0)
  tiled_sram #(.DATA_W(DW), .DEPTH(DP), .TILE_W(8), .TILE_D(16), .MASK_GRAN(4),
               .TILE_GRAN(8), .PORT_HAS_RE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .mem_ce(ce), .mem_we(we), .mem_re(re_tie),
    .mem_addr(addr), .mem_wdata(wd), .mem_wmask(wm), .mem_rdata(rd1));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expect_rd(input int a);
    return (a < DP) ? mdl[a] : '0;
  endfunction

  task automatic wr(input int a, input logic [DW-1:0] d, input logic [MW-1:0] m);
    ce = 1'b1; we = 1'b1; re = 1'b0; addr = AW'(a); wd = d; wm = m;
    @(negedge clk);
    if (a < DP) begin
      for (int b = 0; b < DW; b++) if (m[b/4]) mdl[a][b] = d[b];
    end
    ce = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int a, input string req0, input string req1);
    ce = 1'b1; we = 1'b0; re = 1'b1; addr = AW'(a);
    @(negedge clk);
    chk(req0, rd0, expect_rd(a));
    chk(req1, rd1, expect_rd(a));
    ce = 1'b0; re = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] held;
    for (int a = 0; a < 64; a++) mdl[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset u0", rd0, '0);
    chk("R10 reset u1", rd1, '0);

    // R1/R2 full sweep, including addresses past the depth
    for (int a = 0; a < 64; a++) wr(a, DW'(a * 37 + 5), '1);
    for (int a = 0; a < DP; a++) rd(a, "R1 sweep u0", "R9 sweep u1");
    // R6 reads past depth
    for (int a = DP; a < 64; a++) rd(a, "R6 oob u0", "R6 oob u1");

    // R3 writes past depth must not corrupt the aliased rows
    for (int a = DP; a < 64; a++) wr(a, 12'h5A5, '1);
    for (int a = 0; a < 16; a++) rd(a + 32, "R3 alias u0", "R3 alias u1");
    for (int a = 0; a < 16; a++) rd(a, "R3 alias low u0", "R3 alias low u1");

    // R2 bank boundaries, R7/R9 every mask pattern
    foreach (mdl[i]) begin end
    for (int s = 0; s < 6; s++) begin
      int a;
      a = (s % 2 == 0) ? (s / 2) * 16 : (s / 2) * 16 + 15;
      for (int m = 0; m < 8; m++) begin
        wr(a, 12'h000, '1);
        wr(a, 12'hABC, MW'(m));
        rd(a, "R7 mask u0", "R9 mask u1");
      end
    end
    rd(15, "R2 boundary 15 u0", "R2 boundary 15 u1");
    rd(16, "R2 boundary 16 u0", "R2 boundary 16 u1");
    rd(31, "R2 boundary 31 u0", "R2 boundary 31 u1");
    rd(32, "R2 boundary 32 u0", "R2 boundary 32 u1");

    // R5 hold: write to the address just read, then a cycle with ce low
    rd(20, "R4 latency u0", "R8 read without re u1");
    held = rd0;
    wr(20, ~held, '1);
    chk("R5 hold after write", rd0, held);
    ce = 1'b0; re = 1'b1; addr = AW'(20);
    @(negedge clk);
    chk("R5 hold ce low", rd0, held);
    ce = 1'b1; re = 1'b0; we = 1'b0;
    @(negedge clk);
    chk("R5 hold re low", rd0, held);
    chk("R8 ce without re reads u1", rd1, mdl[20]);
    ce = 1'b0;
    rd(20, "R4 new data u0", "R8 new data u1");

    // Random masked traffic across banks, R4 back-to-back reads
    for (int i = 0; i < 600; i++) begin
      int a;
      a = int'($urandom_range(63, 0));
      if ($urandom_range(1, 0) == 0)
        wr(a, DW'($urandom()), MW'($urandom_range(7, 0)));
      else
        rd(a, "R4 random u0", "R8 random u1");
    end
    for (int a = 0; a < 64; a++) rd(a, "R1 final u0", "R9 final u1");

    finish_run();
  end

endmodule